// File: doc/BRIEF.md
# Three-Opcode Byte Machine Core

This core is a small sequential processor that executes a three-instruction subset of a byte-addressed 32-bit machine code. Its architectural state is an 8-bit accumulator and a 32-bit program counter. Every instruction is five bytes long: an opcode byte, then a 32-bit address operand stored least significant byte first. The three operations are:

- a load of one byte into the accumulator from an absolute address;
- a store of the accumulator to an absolute address;
- a jump by a signed offset relative to the following instruction.

All traffic goes through one byte-wide memory port that serves both code and data. The port carries an address, write data, a write enable, read data, and a ready input. Instruction bytes are fetched one at a time, just before they are needed, and nothing is fetched early. A store that patches an operand of a later instruction is therefore seen when that instruction runs. Programs use this to build indirect addressing and table lookups from plain moves.

Any opcode byte that is not one of the three stops the core. The halt output then rises and stays high until reset, and the program counter keeps the address of the offending instruction. The accumulator and program counter are brought out as ports so that the surrounding system can observe the machine state.

Top module: `byteop_core`

## Requirements
- R1: While synchronous reset is high at a clock edge, the core clears the accumulator to 0, loads the program counter with RESET_VEC (default 0), and clears halt. After reset the first access presents address RESET_VEC with mem_req high and mem_we low.
- R2: An instruction is fetched as five read accesses at addresses pc, pc+1, pc+2, pc+3 and pc+4, in that order. Each access completes in a cycle where mem_ready is high.
- R3: The operand is little-endian. The byte at pc+1 is bits 7:0 and the byte at pc+4 is bits 31:24.
- R4: Opcode 0xA0 reads the byte at the absolute operand address in a sixth access and places it in the accumulator.
- R5: Opcode 0xA2 writes the accumulator to the absolute operand address in a sixth access. mem_we is high only during that access, and the store leaves the accumulator unchanged.
- R6: Opcode 0xE9 sets pc to pc + 5 + operand, modulo 2^32. The operand is treated as a signed offset, so 0xFFFFFFE7 moves backwards and wraps below address 0.
- R7: After a load or store, pc increases by exactly 5. pc changes at no other time except when a jump retires.
- R8: While mem_ready is low, the core holds its address, accumulator and program counter unchanged.
- R9: A load or a store takes exactly 6 ready accesses and a jump takes exactly 5. With mem_ready held high, each access takes one cycle.
- R10: Any other opcode value costs exactly one access. It then sets halt, which stays high until reset. pc keeps the address of that opcode, and mem_req and mem_we stay low.
- R11: A store into an operand byte of a later instruction changes the address that instruction uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | An access is being presented (low once halted) |
| mem_addr | output | 32 | Byte address of the current access |
| mem_we | output | 1 | Current access is a write |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid when mem_ready is high |
| mem_ready | input | 1 | Current access completes at this edge |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 32 | Program counter (address of the current instruction) |
| halt | output | 1 | Sticky stop flag after an undefined opcode |

## Verification
The bench generates straight-line random programs that mix loads from the whole address range with random upper operand bits, stores into a data area, and forward jumps that skip zero, one or two slots. Each program ends in a random undefined opcode. Each program is run either with mem_ready always high or with random wait states. This separates errors in the access counts, which show up in either mode, from errors in stall handling, which only the random wait states expose.

A bench interpreter computes the final memory image, accumulator, program counter and access count. Any mistake in operand byte order, jump arithmetic or program counter stepping shows up as a different final state. A directed program checks a patched operand and a backward jump that wraps below address zero. Together they separate true self-modification and signed wrap-around from a design that buffers operands or adds the offset unsigned. Further directed cases cover a reset in the middle of a run and a long stall right after reset.

// File: rtl/bop_pkg.sv
package bop_pkg;

  localparam logic [7:0] OPC_LOAD  = 8'hA0;
  localparam logic [7:0] OPC_STORE = 8'hA2;
  localparam logic [7:0] OPC_JUMP  = 8'hE9;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_OPD = 2'd1,
    PH_EXE = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    K_LD  = 2'd0,
    K_ST  = 2'd1,
    K_JMP = 2'd2
  } kind_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
  } dec_t;

  function automatic dec_t decode_opc(input logic [7:0] b);
    dec_t d;
    d.legal = 1'b1;
    d.kind  = K_LD;
    case (b)
      OPC_LOAD:  d.kind = K_LD;
      OPC_STORE: d.kind = K_ST;
      OPC_JUMP:  d.kind = K_JMP;
      default:   d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bop_seq.sv
module bop_seq
  import bop_pkg::*;
#(
  parameter int NB = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ready,
  input  logic [7:0]    opc_byte,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o,
  output kind_e         kind_o,
  output logic          halt_o,
  output logic          step_o,
  output logic          last_opd_o,
  output logic          fetch_adv_o
);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  kind_e         kind_q;
  logic          halt_q;
  dec_t          dec;

  assign dec        = decode_opc(opc_byte);
  assign step_o     = mem_ready && !halt_q;
  assign last_opd_o = (phase_q == PH_OPD) && (idx_q == IW'(NB - 1));
  assign fetch_adv_o = step_o &&
                       (((phase_q == PH_OPC) && dec.legal) ||
                        ((phase_q == PH_OPD) && !last_opd_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OPC;
      idx_q   <= '0;
      kind_q  <= K_LD;
      halt_q  <= 1'b0;
    end else if (step_o) begin
      case (phase_q)
        PH_OPC: begin
          if (dec.legal) begin
            kind_q  <= dec.kind;
            phase_q <= PH_OPD;
            idx_q   <= '0;
          end else begin
            halt_q  <= 1'b1;
          end
        end
        PH_OPD: begin
          if (last_opd_o) begin
            phase_q <= (kind_q == K_JMP) ? PH_OPC : PH_EXE;
            idx_q   <= '0;
          end else begin
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: phase_q <= PH_OPC;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign kind_o  = kind_q;
  assign halt_o  = halt_q;

endmodule

// File: rtl/bop_operand.sv
module bop_operand #(
  parameter int DATA_W = 8,
  parameter int NB     = 4,
  localparam int IW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic [IW-1:0]        idx,
  input  logic [DATA_W-1:0]    rdata,
  output logic [NB*DATA_W-1:0] operand_q,
  output logic [NB*DATA_W-1:0] operand_full
);

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    logic              hit;

    assign hit = cap && (idx == IW'(k));

    always_ff @(posedge clk) begin
      if (rst)      lane_q <= '0;
      else if (hit) lane_q <= rdata;
    end

    assign operand_q[k*DATA_W +: DATA_W]    = lane_q;
    assign operand_full[k*DATA_W +: DATA_W] = hit ? rdata : lane_q;
  end

endmodule

// File: rtl/bop_dp.sv
module bop_dp
  import bop_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  localparam int             NB        = ADDR_W / DATA_W,
  localparam int             IW        = (NB > 1) ? $clog2(NB) : 1,
  localparam int             INSTR_LEN = NB + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic [IW-1:0]     idx,
  input  kind_e             kind,
  input  logic              step,
  input  logic              last_opd,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] operand_q,
  input  logic [ADDR_W-1:0] operand_full,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              retire,
  output logic              jump
);

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INSTR_LEN);
  endfunction

  function automatic logic [ADDR_W-1:0] jump_dest(input logic [ADDR_W-1:0] pc,
                                                  input logic [ADDR_W-1:0] off);
    return pc + ADDR_W'(INSTR_LEN) + off;
  endfunction

  logic [DATA_W-1:0] acc_q;
  logic [ADDR_W-1:0] pc_q;
  logic              exe_fire;

  assign exe_fire = step && (phase == PH_EXE);
  assign jump     = step && last_opd && (kind == K_JMP);
  assign retire   = exe_fire || jump;

  always_comb begin
    case (phase)
      PH_OPD:  mem_addr = pc_q + ADDR_W'(idx) + ADDR_W'(1);
      PH_EXE:  mem_addr = operand_q;
      default: mem_addr = pc_q;
    endcase
  end

  assign mem_we    = (phase == PH_EXE) && (kind == K_ST);
  assign mem_wdata = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pc_q  <= RESET_VEC;
    end else begin
      if (exe_fire) begin
        pc_q <= seq_next(pc_q);
        if (kind == K_LD) acc_q <= rdata;
      end else if (jump) begin
        pc_q <= jump_dest(pc_q, operand_full);
      end
    end
  end

  assign acc_o = acc_q;
  assign pc_o  = pc_q;

endmodule

// File: rtl/byteop_core.sv
module byteop_core
  import bop_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halt
);

  localparam int NB = ADDR_W / DATA_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  phase_e            phase;
  logic [IW-1:0]     idx;
  kind_e             kind;
  logic              halt_i;
  logic              step;
  logic              last_opd;
  logic [ADDR_W-1:0] operand_q;
  logic [ADDR_W-1:0] operand_full;
  logic              we_i;

  // named events for the checker
  logic ev_retire;
  logic ev_jump;
  logic ev_fetch_adv;
  logic ev_exec_phase;

  bop_seq #(.NB(NB)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .mem_ready   (mem_ready),
    .opc_byte    (mem_rdata[7:0]),
    .phase_o     (phase),
    .idx_o       (idx),
    .kind_o      (kind),
    .halt_o      (halt_i),
    .step_o      (step),
    .last_opd_o  (last_opd),
    .fetch_adv_o (ev_fetch_adv)
  );

  bop_operand #(.DATA_W(DATA_W), .NB(NB)) u_opd (
    .clk          (clk),
    .rst          (rst),
    .cap          (step && (phase == PH_OPD)),
    .idx          (idx),
    .rdata        (mem_rdata),
    .operand_q    (operand_q),
    .operand_full (operand_full)
  );

  bop_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_VEC(RESET_VEC)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .phase        (phase),
    .idx          (idx),
    .kind         (kind),
    .step         (step),
    .last_opd     (last_opd),
    .rdata        (mem_rdata),
    .operand_q    (operand_q),
    .operand_full (operand_full),
    .mem_addr     (mem_addr),
    .mem_we       (we_i),
    .mem_wdata    (mem_wdata),
    .acc_o        (acc_o),
    .pc_o         (pc_o),
    .retire       (ev_retire),
    .jump         (ev_jump)
  );

  assign ev_exec_phase = (phase == PH_EXE);
  assign mem_req       = !halt_i;
  assign mem_we        = we_i && !halt_i;
  assign halt          = halt_i;

endmodule

// File: rtl/bop_core_chk.sv
module bop_core_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  localparam int INSTR_LEN = ADDR_W / DATA_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              halt,
  input logic              ev_retire,
  input logic              ev_jump,
  input logic              ev_fetch_adv,
  input logic              ev_exec_phase
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> $stable(mem_addr) && $stable(pc_o) && $stable(acc_o)); // R8

  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_adv |=> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R2

  AST_WE_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ev_exec_phase && !ev_fetch_adv); // R5

  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    mem_we && mem_ready |=> $stable(acc_o)); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    ev_retire && !ev_jump |=> pc_o == $past(pc_o) + ADDR_W'(INSTR_LEN)); // R7

  AST_PC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ev_retire |=> $stable(pc_o)); // R7

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt); // R10

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halt |-> !mem_req && !mem_we && !ev_retire); // R10

endmodule

bind byteop_core bop_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_req       (mem_req),
  .mem_ready     (mem_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .acc_o         (acc_o),
  .pc_o          (pc_o),
  .halt          (halt),
  .ev_retire     (ev_retire),
  .ev_jump       (ev_jump),
  .ev_fetch_adv  (ev_fetch_adv),
  .ev_exec_phase (ev_exec_phase)
);

// File: tb/byteop_core_test.sv
`timescale 1ns/1ps
module byteop_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, halt;
  logic [31:0] mem_addr, pc_o;
  logic [7:0]  mem_wdata, mem_rdata, acc_o;
  logic        mem_ready = 1'b0;

  logic [7:0]  mem   [0:1023];
  logic [7:0]  init  [0:1023];
  logic [7:0]  rmem  [0:1023];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int acc_cnt = 0;
  int ready_pct = 100;

  always #2.5 clk = ~clk;

  byteop_core uut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .acc_o(acc_o), .pc_o(pc_o), .halt(halt)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) acc_cnt <= 0;
    else if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end
  end

  always @(negedge clk) mem_ready <= (($urandom % 100) < ready_pct);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] jmp_tgt(input logic [31:0] pc, input logic [31:0] off);
    logic signed [33:0] s;
    s = $signed({2'b00, pc}) + 34'sd5 + $signed({{2{off[31]}}, off});
    return s[31:0];
  endfunction

  // bench interpreter: returns final pc, acc and access count
  task automatic ref_run(output logic [31:0] r_pc, output logic [7:0] r_acc,
                         output int r_cnt);
    logic [31:0] pc, off;
    logic [7:0]  a, op;
    bit          done;
    pc = 32'h0; a = 8'h0; r_cnt = 0; done = 0;
    for (int i = 0; i < 1024; i++) rmem[i] = init[i];
    for (int s = 0; s < 400 && !done; s++) begin
      op = rmem[pc[9:0]];
      for (int b = 0; b < 4; b++) off[b*8 +: 8] = rmem[10'(pc + 32'(b + 1))];
      if (op == 8'hA0) begin a = rmem[off[9:0]]; pc = pc + 32'd5; r_cnt += 6; end
      else if (op == 8'hA2) begin rmem[off[9:0]] = a; pc = pc + 32'd5; r_cnt += 6; end
      else if (op == 8'hE9) begin pc = jmp_tgt(pc, off); r_cnt += 5; end
      else begin r_cnt += 1; done = 1; end
    end
    r_pc = pc; r_acc = a;
  endtask

  task automatic put_ins(input int at, input logic [7:0] op, input logic [31:0] v);
    init[at] = op;
    for (int b = 0; b < 4; b++) init[(at + 1 + b) % 1024] = v[b*8 +: 8];
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < 1024; i++) mem[i] = init[i];
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic run_and_compare(input string tag);
    logic [31:0] e_pc; logic [7:0] e_acc; int e_cnt; int t; int bad;
    ref_run(e_pc, e_acc, e_cnt);
    do_reset();
    t = 0;
    while (!halt && t < 6000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(halt === 1'b1, {tag, " R10 halt"}, 32'(halt), 32'h1);
    chk(pc_o === e_pc, {tag, " R6/R7 pc"}, pc_o, e_pc);
    chk(acc_o === e_acc, {tag, " R4 acc"}, 32'(acc_o), 32'(e_acc));
    chk(acc_cnt == e_cnt, {tag, " R9 accesses"}, 32'(acc_cnt), 32'(e_cnt));
    chk(mem_req === 1'b0 && mem_we === 1'b0, {tag, " R10 quiet"},
        32'({mem_req, mem_we}), 32'h0);
    bad = -1;
    for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== rmem[i]) bad = i;
    chk(bad < 0, {tag, " R5 memory image"}, 32'(bad), 32'hFFFFFFFF);
  endtask

  task automatic rand_program();
    int slots; logic [7:0] il;
    for (int i = 0; i < 1024; i++) init[i] = 8'($urandom);
    slots = 10 + ($urandom % 6);
    for (int s = 0; s < slots; s++) begin
      int r; r = $urandom % 10;
      if (r < 4)      put_ins(5*s, 8'hA0, $urandom);
      else if (r < 7) put_ins(5*s, 8'hA2, {$urandom % 65536, 6'd0, 10'(10'h200 + ($urandom % 10'h1F0))});
      else            put_ins(5*s, 8'hE9, 32'(5 * ($urandom % 3)));
    end
    do il = 8'($urandom); while (il == 8'hA0 || il == 8'hA2 || il == 8'hE9);
    for (int k = 0; k < 3; k++) put_ins(5*(slots + k), il, $urandom);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] hold_pc;
    void'($urandom(32'd1234));
    // R1 reset state with ready held low; R8 stall holds everything
    ready_pct = 0;
    for (int i = 0; i < 1024; i++) init[i] = 8'h00;
    put_ins(0, 8'hA0, 32'h0000_0100);
    do_reset();
    chk(pc_o === 32'h0 && acc_o === 8'h0 && halt === 1'b0, "R1 reset state",
        {pc_o[23:0], acc_o}, 32'h0);
    chk(mem_addr === 32'h0 && mem_req === 1'b1 && mem_we === 1'b0, "R1 first access",
        mem_addr, 32'h0);
    repeat (5) @(negedge clk);
    chk(mem_addr === 32'h0 && pc_o === 32'h0, "R8 stall holds address", mem_addr, 32'h0);

    // R2/R3 operand fetch order with single-cycle accesses
    ready_pct = 100;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      chk(mem_addr === 32'(b + 1), "R2 operand byte address", mem_addr, 32'(b + 1));
      @(negedge clk);
    end
    chk(mem_addr === 32'h100, "R3 little-endian operand", mem_addr, 32'h100);

    // directed: self-modification and wrapping backward jump (R11, R6)
    for (int i = 0; i < 1024; i++) init[i] = 8'h00;
    init[10'h200] = 8'h77; init[10'h377] = 8'h5A; init[10'h300] = 8'h11;
    put_ins(0,  8'hA0, 32'h0000_0200);
    put_ins(5,  8'hA2, 32'h0000_000B);
    put_ins(10, 8'hA0, 32'h0000_0300);
    put_ins(15, 8'hE9, 32'hFFFF_FFE7);
    put_ins(10'h3FB, 8'hE9, 32'h0000_0014);
    put_ins(20, 8'hA2, 32'h0000_0210);
    put_ins(25, 8'hFF, 32'h0);
    ready_pct = 60;
    run_and_compare("directed");
    chk(acc_o === 8'h5A, "R11 patched operand used", 32'(acc_o), 32'h5A);
    chk(mem[10'h210] === 8'h5A, "R5 store data", 32'(mem[10'h210]), 32'h5A);
    chk(pc_o === 32'd25, "R10 pc held at bad opcode", pc_o, 32'd25);
    chk(acc_cnt == 35, "R9 directed access count", 32'(acc_cnt), 32'd35);
    chk(jmp_tgt(32'd15, 32'hFFFF_FFE7) == 32'hFFFF_FFFB, "R6 wrap arithmetic",
        jmp_tgt(32'd15, 32'hFFFF_FFE7), 32'hFFFF_FFFB);

    // R1 reset in mid-run
    rand_program();
    ready_pct = 100;
    do_reset();
    repeat (9) @(negedge clk);
    rst = 1'b1; @(negedge clk);
    chk(pc_o === 32'h0 && acc_o === 8'h0 && halt === 1'b0, "R1 mid-run reset",
        pc_o, 32'h0);
    rst = 1'b0;

    // constrained random programs
    for (int p = 0; p < 40; p++) begin
      rand_program();
      ready_pct = (p % 2 == 0) ? 100 : 55;
      run_and_compare($sformatf("rand%0d", p));
    end

    hold_pc = pc_o;
    repeat (4) @(negedge clk);
    chk(halt === 1'b1 && pc_o === hold_pc, "R10 halt sticky", pc_o, hold_pc);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule